// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host-side master for reading the 24-bit result frame of a delta-sigma converter over a three-wire serial link. After a start request it pulls chip select low with the serial clock held low. It then watches the converter's data line, which the converter holds high while a conversion is running and drives low once a result is waiting. Clocking begins only after the line has been seen low.

The controller generates the serial clock from the system clock. It samples the data line at each rising edge of the serial clock, because the converter changes the data after falling edges. The first bit it samples is the converter's status bit, which is kept in its own flag. The remaining bits are packed from the top of a 23-bit result word.

A programmed bit count can stop the frame early. In that case chip select goes high again before the frame is complete, which aborts the frame and makes the converter start a new conversion. A two-wire mode keeps chip select low at all times and relies only on the data line to signal a finished conversion.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `cs_n` is 1, `sclk` is 0, and `busy` and `valid` are 0. This assumes `two_wire` is 0 during reset.
- R2: Chip select falls only while `sclk` is low. The first rising edge of `sclk` comes no sooner than HALF_DIV system cycles after a read starts.
- R3: While `sdo` reads 1 in the polling phase, no `sclk` edge is produced. Clocking starts only after `sdo` has been sampled as 0.
- R4: Each high phase of `sclk` lasts exactly HALF_DIV system cycles. `sdo` is captured at the moment `sclk` is driven high.
- R5: The first sampled bit is placed in `status_bit`. Sampled bit k (k = 2..N) goes to `result[24-k]`, so the second bit lands in bit 22. Result positions that are not read are 0. Both outputs change only when `valid` is asserted.
- R6: The number of bits read, N, equals `bit_count` when that value is between 1 and 24. A `bit_count` of 0 or any value above 24 gives N = 24. Exactly N rising edges of `sclk` occur per read.
- R7: After the Nth falling edge of `sclk`, `valid` pulses for exactly one system cycle and `busy` is 0 in that same cycle. In three-wire mode `cs_n` is already 1 at that point.
- R8: `truncated` is 1 together with `valid` exactly when N < 24.
- R9: When `two_wire` is 1, `cs_n` stays low while idle and during the whole read. In this mode `bit_count` is overridden and N = 24.
- R10: A `start` pulse while `busy` is 1 is ignored. Changes to `bit_count` or `two_wire` after a read has started do not affect that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read; sampled only while idle |
| bit_count | input | 5 | Bits to read, 1..24 (other values give 24) |
| two_wire | input | 1 | 1 selects two-wire mode with chip select held low |
| sdo | input | 1 | Serial data and status line from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A read is in progress |
| valid | output | 1 | One-cycle strobe when a read finishes |
| truncated | output | 1 | The finished read was a partial read |
| status_bit | output | 1 | First bit sampled in the last read |
| result | output | 23 | Remaining bits, left-aligned |

## Verification
The hardest case to reach from the ports is a read that starts while the converter is still busy. The controller must then keep polling over many divided periods without producing a single clock edge, and it must start clocking within one divided period once the line drops. The bench models the converter itself and holds its busy level high for a random number of system cycles before each read. It counts `sclk` rising edges while the model is busy and checks that the count is zero. During some reads the bench also pulses `start` again and changes the mode and bit-count inputs mid-read, and it confirms that the frame length and chip-select behaviour still follow the values latched at the start.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_POLL,
    ST_SHIFT,
    ST_DONE
  } rdo_state_e;
endpackage

// File: rtl/rdo_tick_gen.sv
module rdo_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R4: two ticks never arrive in consecutive cycles
      a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rdo_len_sel.sv
module rdo_len_sel #(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5
) (
  input  logic [CNT_W-1:0] req,
  input  logic             two_wire,
  output logic [CNT_W-1:0] len,
  output logic             partial
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  always_comb begin
    if (two_wire || req == '0 || req > FULL) len = FULL;
    else                                     len = req;
    partial = (len != FULL);
  end
endmodule

// File: rtl/rdo_capture.sv
module rdo_capture #(
  parameter int FRAME_BITS = 24,
  parameter int CNT_W      = 5,
  localparam int RES_W     = FRAME_BITS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] idx,
  input  logic             din,
  output logic             status,
  output logic [RES_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      status <= 1'b0;
      word   <= '0;
    end else if (load) begin
      if (idx == '0) status <= din;
      for (int b = 0; b < RES_W; b++) begin
        if (idx == CNT_W'(FRAME_BITS - 1 - b)) word[b] <= din;
      end
    end
  end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 24,
  localparam int CNT_W     = $clog2(FRAME_BITS + 1),
  localparam int RES_W     = FRAME_BITS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] bit_count,
  input  logic             two_wire,
  input  logic             sdo,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             valid,
  output logic             truncated,
  output logic             status_bit,
  output logic [RES_W-1:0] result
);
  import rdo_pkg::*;

  rdo_state_e       state;
  logic [CNT_W-1:0] nb_q, bitn, len_sel;
  logic             tw_q, part_q, part_sel;
  logic             tick, tick_en;
  logic             cap_load, cap_clear, cap_status;
  logic [CNT_W-1:0] cap_idx;
  logic [RES_W-1:0] cap_word;

  assign tick_en = (state == ST_SETUP) || (state == ST_POLL) || (state == ST_SHIFT);

  rdo_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .tick(tick)
  );

  rdo_len_sel #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_len (
    .req(bit_count), .two_wire(two_wire), .len(len_sel), .partial(part_sel)
  );

  assign cap_clear = (state == ST_IDLE) && start;
  assign cap_load  = ((state == ST_POLL) && tick && !sdo) ||
                     ((state == ST_SHIFT) && tick && !sclk);
  assign cap_idx   = (state == ST_POLL) ? '0 : bitn;

  rdo_capture #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .clear(cap_clear), .load(cap_load),
    .idx(cap_idx), .din(sdo), .status(cap_status), .word(cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cs_n       <= 1'b1;
      sclk       <= 1'b0;
      busy       <= 1'b0;
      valid      <= 1'b0;
      truncated  <= 1'b0;
      status_bit <= 1'b0;
      result     <= '0;
      nb_q       <= CNT_W'(FRAME_BITS);
      tw_q       <= 1'b0;
      part_q     <= 1'b0;
      bitn       <= '0;
    end else begin
      valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          cs_n <= ~two_wire;
          sclk <= 1'b0;
          if (start) begin
            nb_q   <= len_sel;
            part_q <= part_sel;
            tw_q   <= two_wire;
            cs_n   <= 1'b0;
            busy   <= 1'b1;
            bitn   <= '0;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) state <= ST_POLL;
        ST_POLL: begin
          if (tick && !sdo) begin
            sclk  <= 1'b1;
            bitn  <= CNT_W'(1);
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk) begin
              sclk <= 1'b0;
              if (bitn == nb_q) begin
                cs_n  <= ~tw_q;
                state <= ST_DONE;
              end
            end else begin
              sclk <= 1'b1;
              bitn <= bitn + 1'b1;
            end
          end
        end
        ST_DONE: begin
          valid      <= 1'b1;
          truncated  <= part_q;
          busy       <= 1'b0;
          status_bit <= cap_status;
          result     <= cap_word;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: chip select only falls with the serial clock low
  a_r2_sclk_low_at_select: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sclk);
  // R2: no clock activity before polling starts
  a_r2_setup_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETUP) |-> !sclk);
  // R3: polling never drives the serial clock high
  a_r3_poll_no_clock: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL) |-> !sclk);
  // R3: the clock is only high with the converter selected
  a_r3_clock_needs_select: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);
  // R6: the bit counter stays within the latched length
  a_r6_bits_bounded: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (bitn != '0 && bitn <= nb_q));
  // R7: the completion strobe is a single cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R7: three-wire reads end with chip select released
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (valid && !tw_q) |-> cs_n);
  // R9: two-wire reads never release chip select
  a_r9_hold_select: assert property (@(posedge clk) disable iff (rst)
    (tw_q && state != ST_IDLE) |-> !cs_n);
endmodule

// File: tb/sim_adc_readout_ctrl.sv
module sim_adc_readout_ctrl;
  localparam int HD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  bit_count = 5'd24;
  logic        two_wire = 1'b0;
  logic        sdo;
  logic        cs_n, sclk, busy, valid, truncated, status_bit;
  logic [22:0] result;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int rises = 0;
  int bitptr = 0;
  int hi_run = 0;
  int hi_err = 0;
  logic        conv_busy = 1'b1;
  logic [23:0] frame = '0;

  always #10 clk = ~clk;

  adc_readout_ctrl #(.HALF_DIV(HD), .FRAME_BITS(24)) u0 (
    .clk(clk), .rst(rst), .start(start), .bit_count(bit_count),
    .two_wire(two_wire), .sdo(sdo), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .valid(valid), .truncated(truncated), .status_bit(status_bit), .result(result)
  );

  // converter model: busy level or frame bit while selected
  assign sdo = cs_n ? 1'b1 : (conv_busy ? 1'b1 : (bitptr < 24 ? frame[23 - bitptr] : 1'b1));
  always @(negedge sclk) bitptr = bitptr + 1;
  always @(posedge sclk) rises = rises + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (sclk === 1'b1) hi_run = hi_run + 1;
      else if (hi_run != 0) begin
        if (hi_run != HD) hi_err = hi_err + 1;
        hi_run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int norm_len(input int req, input bit tw);
    if (tw || req == 0 || req > 24) return 24;
    return req;
  endfunction

  function automatic logic [22:0] exp_word(input logic [22:0] d, input int n);
    logic [31:0] m;
    m = 32'h7FFFFF & ~((32'd1 << (24 - n)) - 32'd1);
    return d & m[22:0];
  endfunction

  task automatic do_read(input logic [22:0] data, input int req, input bit tw,
                         input int busy_cycles, input bit glitch);
    int cyc;
    int n;
    n = norm_len(req, tw);
    frame = {1'b0, data};
    bitptr = 0;
    conv_busy = 1'b1;
    two_wire = tw;
    bit_count = 5'(req);
    @(negedge clk);
    rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && cs_n === 1'b0, "R2 select after start", {busy, cs_n}, 2'b10);
    cyc = 0;
    while (sclk !== 1'b1 && cyc < 5000) begin
      if (cyc == busy_cycles) conv_busy = 1'b0;
      if (glitch && cyc == 1) begin
        start = 1'b1;
        bit_count = 5'(($urandom % 24) + 1);
        two_wire = ~tw;
      end
      if (glitch && cyc == 2) begin
        start = 1'b0;
        two_wire = tw;
      end
      if (conv_busy && rises != 0) break;
      @(negedge clk);
      cyc++;
    end
    chk(cyc >= HD && cyc > busy_cycles, "R2/R3 first rise delay", cyc, busy_cycles + 1);
    start = 1'b0;
    two_wire = tw;
    while (valid !== 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(valid === 1'b1, "R7 valid seen", valid, 1);
    chk(busy === 1'b0, "R7 busy low with valid", busy, 0);
    chk(rises == n, "R6 edge count", rises, n);
    chk(truncated === (n < 24), "R8 truncated", truncated, n < 24);
    chk(status_bit === 1'b0, "R5 status bit", status_bit, 0);
    chk(result === exp_word(data, n), "R5 result", result, exp_word(data, n));
    chk(cs_n === ~tw, "R7/R9 chip select at end", cs_n, ~tw);
    @(negedge clk);
    chk(valid === 1'b0, "R7 valid single cycle", valid, 0);
    if (glitch) chk(busy === 1'b0, "R10 second start ignored", busy, 0);
    conv_busy = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && valid === 1'b0,
        "R1 reset state", {cs_n, sclk, busy, valid}, 4'b1000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && valid === 1'b0,
        "R1 idle after reset", {cs_n, sclk, busy, valid}, 4'b1000);

    // directed corner cases
    do_read(23'h5A5A5A, 24, 1'b0, 0, 1'b0);
    do_read(23'h7FFFFF, 1, 1'b0, 37, 1'b0);
    do_read(23'h7FFFFF, 2, 1'b0, 5, 1'b0);
    do_read(23'h2AAAAA, 0, 1'b0, 12, 1'b0);   // R6 zero count
    do_read(23'h155555, 31, 1'b0, 3, 1'b0);   // R6 oversize count
    do_read(23'h123456, 10, 1'b0, 250, 1'b1); // R10 mid-read changes
    rises = 0;
    two_wire = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b0, "R9 idle select low", cs_n, 0);
    chk(rises == 0 && busy === 1'b0, "R3 no clock without start", rises, 0);
    do_read(23'h6B3C1D, 7, 1'b1, 40, 1'b0);   // R9 count overridden
    do_read(23'h0F0F0F, 24, 1'b1, 0, 1'b1);
    two_wire = 1'b0;

    // constrained random reads
    for (int i = 0; i < 40; i++) begin
      do_read(23'($urandom), int'($urandom % 28), ($urandom % 5) == 0,
              int'($urandom % 300), ($urandom % 6) == 0);
    end

    chk(hi_err == 0, "R4 clock high phase length", hi_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule